// File: doc/BRIEF.md
# Sync-Gated Receive Bit Buffer

This block sits behind a bit-level demodulator and clock recovery stage. It accepts one received bit on each recovered-clock strobe and holds up to sixteen of them. The host takes them out a byte at a time, and the oldest bit always comes out first. Nothing is stored until the block is armed. It arms in one of two ways: it sees the sixteen-bit synchronisation word 0x2DD4 in the bit stream, or the host selects unconditional filling. In both cases, bits are stored only while the valid-data input is high.

The host controls the block with three inputs: a fill-enable bit, a start-condition select and a four-bit level threshold. It reads three flags back. The level flag is set when the number of stored bits reaches the threshold. The overflow flag is sticky and records that a bit was lost. The empty flag shows that no bits are held. Clearing fill-enable stops filling and drops the sync lock, so a new sync search starts only after fill-enable is set again.

Top module: `sgf_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the stored bits and the sync lock. After that edge, empty_flag=1, lvl_flag=0, ovf_flag=0 and rd_data=0.
- R2: With start_sel=1, fill_en=1 and data_valid=1, every bit_stb stores bit_in.
- R3: With start_sel=0, no bit is stored until the sixteen most recent strobed bits equal 0x2DD4, with the earliest received bit as the MSB. The strobe that completes the match is not stored. Storing begins with the next strobe.
- R4: A strobe that arrives while data_valid=0 stores nothing.
- R5: While fill_en=0 nothing is stored and the sync lock is cleared. After fill_en is set again with start_sel=0, storing needs a fresh match of the sync word.
- R6: When rd_req is high at a clock edge, the eight oldest stored bits appear on rd_data after that edge. The oldest bit is in bit 7. The eight bits are removed from the buffer.
- R7: A read with fewer than eight bits stored returns those bits left-aligned in rd_data, with zeros below them, and empties the buffer. A read of an empty buffer returns 0x00.
- R8: lvl_flag is 1 exactly when the stored count is nonzero and greater than or equal to lvl_thr. It falls when a read brings the count below the threshold.
- R9: A strobe that would be stored while sixteen bits are held is dropped and sets ovf_flag. The stored bits do not change. ovf_flag stays set until stat_rd is high at an edge, and then it clears.
- R10: empty_flag is 1 exactly when no bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Received data bit |
| bit_stb | input | 1 | Recovered bit-clock strobe, one cycle per bit |
| data_valid | input | 1 | Valid-data indication from the demodulator |
| fill_en | input | 1 | Enables filling and arms the sync search |
| start_sel | input | 1 | 0: wait for the sync word, 1: fill at once |
| lvl_thr | input | 4 | Bit-count threshold for lvl_flag |
| rd_req | input | 1 | Byte read request |
| stat_rd | input | 1 | Status read strobe, clears ovf_flag |
| rd_data | output | 8 | Byte returned by the last read, oldest bit in bit 7 |
| lvl_flag | output | 1 | Stored count has reached the threshold |
| ovf_flag | output | 1 | Sticky flag: a bit was lost to a full buffer |
| empty_flag | output | 1 | No bits are stored |

## Verification
The bench targets the strobe that completes the sync word. A design that stores that strobe would put the last sync bit at the front of the first byte. The bench also checks partial reads: a design that right-aligns the leftover bits, or does not zero-fill them, would return the wrong byte. For overflow, it confirms that the dropped bit never reaches the output, which catches a design that overwrites the oldest entry. For re-arming, it confirms that a stale lock does not survive a fill-enable cycle, which catches a design that keeps storing without a new sync word.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
  localparam int unsigned SGF_DEPTH  = 16;
  localparam int unsigned SGF_BYTE   = 8;
  localparam int unsigned SGF_SYNC_W = 16;
  localparam logic [15:0] SGF_SYNC   = 16'h2DD4;
  localparam int unsigned SGF_LVL_W  = 4;
endpackage

// File: rtl/sgf_sync_det.sv
module sgf_sync_det #(
  parameter int unsigned SYNC_W = sgf_pkg::SGF_SYNC_W,
  parameter logic [SYNC_W-1:0] SYNC_WORD = sgf_pkg::SGF_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic stb,
  input  logic din,
  output logic locked
);
  localparam int unsigned NW = $clog2(SYNC_W + 1);

  logic [SYNC_W-1:0] shreg;
  logic [SYNC_W-1:0] shnext;
  logic [NW-1:0]     seen;

  assign shnext = {shreg[SYNC_W-2:0], din};

  // seen counts strobes since arming so reset zeros never count as pattern bits
  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      shreg  <= '0;
      seen   <= '0;
      locked <= 1'b0;
    end else if (stb) begin
      shreg <= shnext;
      if (seen != NW'(SYNC_W)) seen <= seen + 1'b1;
      if (seen >= NW'(SYNC_W - 1) && shnext == SYNC_WORD) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/sgf_bitstore.sv
module sgf_bitstore #(
  parameter int unsigned DEPTH  = sgf_pkg::SGF_DEPTH,
  parameter int unsigned BYTE_W = sgf_pkg::SGF_BYTE,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              din,
  input  logic              rd,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CW-1:0]     cnt_nxt,
  output logic              drop
);
  logic [DEPTH-1:0]  mem;
  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt, take;
  logic              accept;
  logic [BYTE_W-1:0] peek;

  always_comb begin
    if (!rd)                       take = '0;
    else if (cnt > CW'(BYTE_W))    take = CW'(BYTE_W);
    else                           take = cnt;
  end

  // a read in the same cycle frees room for the incoming bit
  assign accept  = wr && ((cnt != CW'(DEPTH)) || rd);
  assign drop    = wr && !accept;
  assign cnt_nxt = cnt - take + CW'(accept);

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) begin
      peek[BYTE_W-1-i] = (CW'(i) < cnt) ? mem[PW'(rptr + PW'(i))] : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      rd_data <= '0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      rptr <= rptr + PW'(take);
      cnt  <= cnt_nxt;
      if (rd) rd_data <= peek;
    end
  end
endmodule

// File: rtl/sgf_flags.sv
module sgf_flags #(
  parameter int unsigned CW    = 5,
  parameter int unsigned LVL_W = sgf_pkg::SGF_LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cnt_nxt,
  input  logic [LVL_W-1:0] thr,
  input  logic             drop,
  input  logic             clr,
  output logic             lvl,
  output logic             empty,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl   <= 1'b0;
      empty <= 1'b1;
      ovf   <= 1'b0;
    end else begin
      empty <= (cnt_nxt == '0);
      lvl   <= (cnt_nxt != '0) && (cnt_nxt >= CW'(thr));
      if (drop)     ovf <= 1'b1;
      else if (clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/sgf_top.sv
module sgf_top #(
  parameter int unsigned DEPTH  = sgf_pkg::SGF_DEPTH,
  parameter int unsigned BYTE_W = sgf_pkg::SGF_BYTE,
  parameter int unsigned SYNC_W = sgf_pkg::SGF_SYNC_W,
  parameter logic [SYNC_W-1:0] SYNC_WORD = sgf_pkg::SGF_SYNC,
  parameter int unsigned LVL_W  = sgf_pkg::SGF_LVL_W,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              data_valid,
  input  logic              fill_en,
  input  logic              start_sel,
  input  logic [LVL_W-1:0]  lvl_thr,
  input  logic              rd_req,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] rd_data,
  output logic              lvl_flag,
  output logic              ovf_flag,
  output logic              empty_flag
);
  logic          locked;
  logic          wr;
  logic          drop;
  logic [CW-1:0] cnt_nxt;

  sgf_sync_det #(.SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)) u_sync (
    .clk(clk), .rst(rst), .arm(fill_en), .stb(bit_stb), .din(bit_in),
    .locked(locked)
  );

  assign wr = bit_stb && fill_en && data_valid && (start_sel || locked);

  sgf_bitstore #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst(rst), .wr(wr), .din(bit_in), .rd(rd_req),
    .rd_data(rd_data), .cnt_nxt(cnt_nxt), .drop(drop)
  );

  sgf_flags #(.CW(CW), .LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .thr(lvl_thr), .drop(drop),
    .clr(stat_rd), .lvl(lvl_flag), .empty(empty_flag), .ovf(ovf_flag)
  );
endmodule

// File: rtl/sgf_chk.sv
module sgf_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LVL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_stb,
  input logic              data_valid,
  input logic              fill_en,
  input logic              rd_req,
  input logic              stat_rd,
  input logic [BYTE_W-1:0] rd_data,
  input logic              lvl_flag,
  input logic              ovf_flag,
  input logic              empty_flag
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (empty_flag && !lvl_flag && !ovf_flag && rd_data == '0));

  p_invalid_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!data_valid && !rd_req && empty_flag) |=> empty_flag);

  p_disabled_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!fill_en && !rd_req && empty_flag) |=> empty_flag);

  p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty_flag) |=> (rd_data == '0));

  p_lvl_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
    empty_flag |-> !lvl_flag);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !stat_rd) |=> ovf_flag);

  p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !bit_stb) |=> !ovf_flag);

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(bit_stb && fill_en && data_valid));
endmodule

bind sgf_top sgf_chk #(.BYTE_W(BYTE_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .data_valid(data_valid),
  .fill_en(fill_en), .rd_req(rd_req), .stat_rd(stat_rd), .rd_data(rd_data),
  .lvl_flag(lvl_flag), .ovf_flag(ovf_flag), .empty_flag(empty_flag)
);

// File: tb/sgf_top_tb_top.sv
module sgf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  localparam logic [15:0] VEC [NVEC] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h1234, 16'h8E71};

  logic       clk = 1'b0;
  logic       rst, bit_in, bit_stb, data_valid, fill_en, start_sel, rd_req, stat_rd;
  logic [3:0] lvl_thr;
  logic [7:0] rd_data;
  logic       lvl_flag, ovf_flag, empty_flag;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgf_top dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_stb(bit_stb),
    .data_valid(data_valid), .fill_en(fill_en), .start_sel(start_sel),
    .lvl_thr(lvl_thr), .rd_req(rd_req), .stat_rd(stat_rd), .rd_data(rd_data),
    .lvl_flag(lvl_flag), .ovf_flag(ovf_flag), .empty_flag(empty_flag)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_stb = 1'b0; rd_req = 1'b0; stat_rd = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobe(input logic b);
    @(negedge clk);
    bit_in = b; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic push16(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) strobe(w[i]);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    b = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    rst = 1'b1; bit_in = 1'b0; bit_stb = 1'b0; data_valid = 1'b1; fill_en = 1'b1;
    start_sel = 1'b1; lvl_thr = 4'd0; rd_req = 1'b0; stat_rd = 1'b0;
    do_reset();
    // R1, R10: reset state
    chk("R1 empty", {7'd0, empty_flag}, 8'd1);
    chk("R1 lvl/ovf", {6'd0, lvl_flag, ovf_flag}, 8'd0);
    chk("R1 rd_data", rd_data, 8'h00);

    // table walk, unconditional fill: R2, R6, R10
    for (int v = 0; v < NVEC; v++) begin
      push16(VEC[v]);
      rd_byte(b); chk("R2/R6 high byte", b, VEC[v][15:8]);
      rd_byte(b); chk("R2/R6 low byte", b, VEC[v][7:0]);
      chk("R10 empty after drain", {7'd0, empty_flag}, 8'd1);
    end

    // R4: strobes with data_valid low are not stored
    data_valid = 1'b0;
    for (int i = 0; i < 4; i++) strobe(1'b1);
    chk("R4 empty", {7'd0, empty_flag}, 8'd1);
    data_valid = 1'b1;

    // R3: sync-gated start
    do_reset();
    start_sel = 1'b0;
    for (int i = 0; i < 8; i++) strobe(1'b1);
    chk("R3 no store before sync", {7'd0, empty_flag}, 8'd1);
    push16(16'h2DD4);
    chk("R3 sync bits not stored", {7'd0, empty_flag}, 8'd1);
    for (int i = 7; i >= 0; i--) strobe(8'hA7 >> i);
    rd_byte(b); chk("R3 first byte after sync", b, 8'hA7);

    // R5: clearing fill_en drops lock and blocks filling
    fill_en = 1'b0;
    for (int i = 0; i < 4; i++) strobe(1'b1);
    chk("R5 disabled no store", {7'd0, empty_flag}, 8'd1);
    @(negedge clk); fill_en = 1'b1;
    for (int i = 0; i < 8; i++) strobe(1'b1);
    chk("R5 relock required", {7'd0, empty_flag}, 8'd1);
    push16(16'h2DD4);
    for (int i = 7; i >= 0; i--) strobe(8'h3C >> i);
    rd_byte(b); chk("R5 store after fresh sync", b, 8'h3C);

    // R7: partial and empty reads
    do_reset();
    start_sel = 1'b1;
    strobe(1'b1); strobe(1'b0); strobe(1'b1);
    rd_byte(b); chk("R7 partial left-aligned", b, 8'hA0);
    chk("R7/R10 empty after partial", {7'd0, empty_flag}, 8'd1);
    rd_byte(b); chk("R7 empty read zero", b, 8'h00);

    // R8: level flag
    lvl_thr = 4'd5;
    strobe(1'b1); strobe(1'b0); strobe(1'b1); strobe(1'b1);
    chk("R8 below threshold", {7'd0, lvl_flag}, 8'd0);
    strobe(1'b0);
    chk("R8 at threshold", {7'd0, lvl_flag}, 8'd1);
    rd_byte(b); chk("R8 read data", b, 8'hB0);
    chk("R8 cleared by read", {7'd0, lvl_flag}, 8'd0);
    lvl_thr = 4'd0;

    // R9: overflow
    push16(16'hF0F0);
    chk("R9 no ovf at full", {7'd0, ovf_flag}, 8'd0);
    strobe(1'b1);
    chk("R9 ovf set", {7'd0, ovf_flag}, 8'd1);
    rd_byte(b); chk("R9 contents kept hi", b, 8'hF0);
    rd_byte(b); chk("R9 contents kept lo", b, 8'hF0);
    chk("R9 ovf sticky", {7'd0, ovf_flag}, 8'd1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R9 ovf cleared by status read", {7'd0, ovf_flag}, 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule